// File: doc/BRIEF.md
# Binary-Code-Modulation LED Shift Driver

This block dims 32 LED channels by binary code modulation. It drives an external chain of latching serial-in, parallel-out shift registers. Each channel holds a 16-bit brightness word, and only the 14 most significant bits take part. The block cuts the table into 14 bit-planes. A bit-plane is one 32-bit word that holds one significance level of every channel. The planes are played in ascending significance. Each plane stays on the outputs for a time weighted by its bit value.

Each bit period has a data cycle and a short clear cycle. In the data cycle the plane is shifted out and then latched. The time from the latch to the end of the data cycle grows as a power of two with the bit index. The clear cycle then pulses the active-low register clear. All timing comes from a prescaled tick counter. The length of each period is loaded only at a rollover, so the frame rate and the duty ratios do not drift.

Brightness words come in on a valid/ready write port. Ready is held high, so the port never applies back-pressure. A word is taken on every clock edge where valid is high. The planes are rebuilt from the table only when a frame wraps, so one frame never mixes old and new levels.

Top module: `bcm_shift_driver`

## Requirements
- R1: Out of reset, ser_clk and ser_data are low, latch is low, clear_n is high and wr_ready is high. The first frame shows all-zero planes.
- R2: wr_ready stays high. A word is stored into channel wr_chan on each edge where wr_valid is high. A later write to the same channel replaces an earlier one, and a cycle with wr_valid low stores nothing.
- R3: Bit j of plane i equals bit i+2 of channel j's word. Bits 1:0 of every word have no effect on the output.
- R4: Planes are played in the order 0, 1, …, 13, and plane 0 follows plane 13.
- R5: The serial format is SPI mode 0 with ser_clk at half the system clock, idling low. The low 16-bit frame (bits 15..0) is sent before the high frame (bits 31..16), each frame MSB first. So serial bit n carries plane bit 15-n for n<16, and plane bit 47-n otherwise.
- R6: Exactly 32 ser_clk rising edges occur between one latch rising edge and the next. All of them fall before the latch rises.
- R7: For plane i, latch is high for (OVH - STROBE_AT + 1 + (BASE<<i)) ticks.
- R8: From the latch rising for plane i to the latch rising for the next plane takes OVH + (BASE<<i) + RST_TC + 2 ticks. This holds across the wrap as well.
- R9: clear_n goes low CLR_AT ticks after latch falls and stays low for CLR_LEN ticks. It is never low while latch is high.
- R10: A write accepted during a frame does not change the planes still to be played in that frame. It shows up from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Brightness write valid |
| wr_ready | output | 1 | Brightness write ready (always high) |
| wr_chan | input | $clog2(NCH) | Channel index of the write |
| wr_level | input | LW | Brightness word; the upper DEPTH bits are used |
| ser_clk | output | 1 | Shift clock to the register chain |
| ser_data | output | 1 | Serial data to the register chain |
| latch | output | 1 | Storage strobe to the register chain |
| clear_n | output | 1 | Active-low clear to the register chain |

## Verification
The hardest case to reach from the ports is a write that lands while a frame is already playing. The write must stay invisible to the rest of that frame and must appear at the very next one. The stimulus follows the latch count and writes a whole new table right after the first plane of a frame has latched. The scoreboard then compares the remaining thirteen planes of that frame against the old table and the next frame against the new one. Other patterns cover the ignored low bits, writes with valid low, double writes to one channel and a lone set bit at the top and bottom planes.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic {
    PH_DATA  = 1'b0,
    PH_CLEAR = 1'b1
  } bcm_phase_e;
endpackage

// File: rtl/bcm_level_store.sv
module bcm_level_store #(
  parameter int NCH   = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 14,
  localparam int CHW  = $clog2(NCH),
  localparam int SKIP = LW - DEPTH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CHW-1:0]             wr_chan,
  input  logic [LW-1:0]              wr_level,
  input  logic                       snap,
  output logic [DEPTH-1:0][NCH-1:0]  planes
);
  logic [NCH-1:0][LW-1:0] levels;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levels <= '0;
    end else if (wr_en) begin
      levels[wr_chan] <= wr_level;
    end
  end

  // Transpose into bit-planes only at frame wrap; old table contents are used
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      planes <= '0;
    end else if (snap) begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < NCH; j++) begin
          planes[i][j] <= levels[j][i+SKIP];
        end
      end
    end
  end
endmodule

// File: rtl/bcm_bit_timer.sv
module bcm_bit_timer
  import bcm_pkg::*;
#(
  parameter int DEPTH     = 14,
  parameter int TICK_DIV  = 2,
  parameter int OVH       = 122,
  parameter int BASE      = 4,
  parameter int STROBE_AT = 120,
  parameter int RST_TC    = 40,
  parameter int CLR_AT    = 1,
  parameter int CLR_LEN   = 1,
  localparam int BW       = $clog2(DEPTH),
  localparam int TOP_TC   = OVH + (BASE << (DEPTH - 1)),
  localparam int MAX_TC   = (TOP_TC > RST_TC) ? TOP_TC : RST_TC,
  localparam int CW       = $clog2(MAX_TC + 1),
  localparam int PW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [BW-1:0] cur_bit,
  output logic          start,
  output logic          wrap,
  output logic          strobe,
  output logic          clr_n
);
  bcm_phase_e    phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tc;
  logic          tick;
  logic [BW-1:0] nxt_bit;
  logic [CW-1:0] nxt_tc;
  logic          strobe_d;
  logic          clr_d;
  logic          at_end;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt <= '0;
        else if (pcnt == PW'(TICK_DIV - 1)) pcnt <= '0;
        else pcnt <= pcnt + 1'b1;
      end
      assign tick = (pcnt == PW'(TICK_DIV - 1));
    end
  endgenerate

  always_comb begin
    nxt_bit  = (cur_bit == BW'(DEPTH - 1)) ? '0 : cur_bit + 1'b1;
    nxt_tc   = CW'(OVH) + (CW'(BASE) << nxt_bit);
    at_end   = (phase == PH_CLEAR) && (cnt == CW'(RST_TC));
    wrap     = tick && at_end && (cur_bit == BW'(DEPTH - 1));
    strobe_d = (phase == PH_DATA) && (cnt >= CW'(STROBE_AT));
    clr_d    = (phase == PH_CLEAR) && (cnt >= CW'(CLR_AT))
               && (cnt < CW'(CLR_AT + CLR_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CLEAR;
      cnt     <= CW'(RST_TC);
      cur_bit <= BW'(DEPTH - 1);
      tc      <= CW'(OVH + BASE);
      start   <= 1'b0;
      strobe  <= 1'b0;
      clr_n   <= 1'b1;
    end else begin
      start  <= 1'b0;
      strobe <= strobe_d;
      clr_n  <= !clr_d;
      if (tick) begin
        if (phase == PH_DATA) begin
          if (cnt == tc) begin
            phase <= PH_CLEAR;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (at_end) begin
            phase   <= PH_DATA;
            cnt     <= '0;
            cur_bit <= nxt_bit;
            tc      <= nxt_tc;
            start   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bcm_plane_shifter.sv
module bcm_plane_shifter #(
  parameter int NCH   = 32,
  parameter int FW    = 16,
  parameter int DEPTH = 14,
  localparam int BW   = $clog2(DEPTH),
  localparam int SCW  = $clog2(2 * NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [BW-1:0]             bit_sel,
  input  logic [DEPTH-1:0][NCH-1:0] planes,
  output logic                      ser_clk,
  output logic                      ser_data,
  output logic                      busy
);
  logic [NCH-1:0] word;
  logic [SCW-1:0] sc;
  int             pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      sc   <= '0;
      busy <= 1'b0;
    end else if (start) begin
      word <= planes[bit_sel];
      sc   <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (sc == SCW'(2 * NCH - 1)) busy <= 1'b0;
      sc <= sc + 1'b1;
    end
  end

  // Frames in ascending order, each frame most significant bit first
  always_comb begin
    int n;
    n   = int'(sc[SCW-1:1]);
    pos = (n / FW) * FW + (FW - 1 - (n % FW));
  end

  assign ser_clk  = busy & sc[0];
  assign ser_data = busy & word[pos];
endmodule

// File: rtl/bcm_shift_driver.sv
module bcm_shift_driver #(
  parameter int NCH       = 32,
  parameter int LW        = 16,
  parameter int DEPTH     = 14,
  parameter int FW        = 16,
  parameter int TICK_DIV  = 2,
  parameter int OVH       = 122,
  parameter int BASE      = 4,
  parameter int STROBE_AT = 120,
  parameter int RST_TC    = 40,
  parameter int CLR_AT    = 1,
  parameter int CLR_LEN   = 1,
  localparam int CHW      = $clog2(NCH),
  localparam int BW       = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [CHW-1:0] wr_chan,
  input  logic [LW-1:0]  wr_level,
  output logic           ser_clk,
  output logic           ser_data,
  output logic           latch,
  output logic           clear_n
);
  logic [DEPTH-1:0][NCH-1:0] planes;
  logic [BW-1:0]             cur_bit;
  logic                      start_pl;
  logic                      wrap;
  logic                      shift_busy;

  assign wr_ready = 1'b1;

  bcm_level_store #(.NCH(NCH), .LW(LW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_valid & wr_ready), .wr_chan(wr_chan), .wr_level(wr_level),
    .snap(wrap), .planes(planes)
  );

  bcm_bit_timer #(
    .DEPTH(DEPTH), .TICK_DIV(TICK_DIV), .OVH(OVH), .BASE(BASE),
    .STROBE_AT(STROBE_AT), .RST_TC(RST_TC), .CLR_AT(CLR_AT), .CLR_LEN(CLR_LEN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .cur_bit(cur_bit), .start(start_pl),
    .wrap(wrap), .strobe(latch), .clr_n(clear_n)
  );

  bcm_plane_shifter #(.NCH(NCH), .FW(FW), .DEPTH(DEPTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_pl), .bit_sel(cur_bit),
    .planes(planes), .ser_clk(ser_clk), .ser_data(ser_data), .busy(shift_busy)
  );
endmodule

// File: rtl/bcm_shift_driver_chk.sv
module bcm_shift_driver_chk #(
  parameter int DEPTH    = 14,
  parameter int TICK_DIV = 2,
  parameter int CLR_LEN  = 1,
  localparam int BW      = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          ser_clk,
  input logic          latch,
  input logic          clear_n,
  input logic          start_pl,
  input logic [BW-1:0] cur_bit,
  input logic          shift_busy
);
  int clr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_run <= 0;
    else if (!clear_n) clr_run <= clr_run + 1;
    else clr_run <= 0;
  end

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R2
  AST_BIT_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pl |-> (cur_bit == (($past(cur_bit) == BW'(DEPTH - 1)) ? '0 : $past(cur_bit) + 1'b1))); // R4
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_busy |-> !ser_clk); // R5
  AST_SHIFT_DONE_AT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> (!shift_busy && !ser_clk)); // R6
  AST_LATCH_CLEAR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch && !clear_n)); // R9
  AST_CLEAR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch) |-> clear_n); // R9
  AST_CLEAR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    clr_run <= CLR_LEN * TICK_DIV); // R9
endmodule

bind bcm_shift_driver bcm_shift_driver_chk #(
  .DEPTH(DEPTH), .TICK_DIV(TICK_DIV), .CLR_LEN(CLR_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .ser_clk(ser_clk),
  .latch(latch), .clear_n(clear_n), .start_pl(start_pl),
  .cur_bit(cur_bit), .shift_busy(shift_busy)
);

// File: tb/bcm_shift_driver_bench.sv
module bcm_shift_driver_bench;
  localparam int NCH = 32, LW = 16, DEPTH = 14, BASE = 1, OVH = 122;
  localparam int STROBE_AT = 120, RST_TC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_chan = '0;
  logic [15:0] wr_level = '0;
  logic        ser_clk, ser_data, latch, clear_n;

  int errors = 0, checks = 0;
  int strobe_cnt = 0;
  bit done = 1'b0;
  logic [15:0] model [NCH];
  logic [31:0] exp_q [$];
  logic [31:0] cur_exp [DEPTH];

  always #2.5 clk = ~clk;

  bcm_shift_driver #(.TICK_DIV(1), .BASE(BASE)) u_bcm_shift_driver (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_level(wr_level), .ser_clk(ser_clk),
    .ser_data(ser_data), .latch(latch), .clear_n(clear_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: push expected planes derived from the model table (R3)
  task automatic push_frame();
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < NCH; j++) w[j] = model[j][i+2];
      exp_q.push_back(w);
    end
  endtask

  task automatic put(input int ch, input logic [15:0] v, input bit vld);
    @(negedge clk);
    wr_valid = vld;
    wr_chan  = 5'(ch);
    wr_level = v;
    chk(wr_ready == 1'b1, "R2", "ready during write", 32'(wr_ready), 1);
    if (vld) model[ch] = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Monitor: capture serial words, compare at latch, measure timing
  logic        p_sclk = 1'b0, p_latch = 1'b0, p_clr = 1'b1;
  logic [31:0] cap = '0;
  int nb = 0, since_rise = 0, high_w = 0, clr_w = 0, since_fall = 0, last_k = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      since_rise++;
      since_fall++;
      if (ser_clk && !p_sclk) begin
        if (nb < 32) cap[(nb < 16) ? (15 - nb) : (47 - nb)] = ser_data;
        nb++;
      end
      if (latch && !p_latch) begin
        int k;
        k = strobe_cnt % DEPTH;
        if (k == 0 && exp_q.size() >= DEPTH)
          for (int i = 0; i < DEPTH; i++) cur_exp[i] = exp_q.pop_front();
        chk(cap == cur_exp[k], "R3/R4/R5/R10", $sformatf("plane %0d word", k), cap, cur_exp[k]);
        chk(nb == 32, "R6", "clock edges per plane", 32'(nb), 32);
        if (strobe_cnt > 0)
          chk(since_rise == OVH + (BASE << last_k) + RST_TC + 2, "R8",
              $sformatf("period after plane %0d", last_k), 32'(since_rise),
              32'(OVH + (BASE << last_k) + RST_TC + 2));
        last_k = k;
        since_rise = 0;
        high_w = 0;
        nb = 0;
        cap = '0;
        strobe_cnt++;
      end
      if (!latch && p_latch) begin
        chk(high_w == OVH - STROBE_AT + 1 + (BASE << last_k), "R7",
            $sformatf("latch width plane %0d", last_k), 32'(high_w),
            32'(OVH - STROBE_AT + 1 + (BASE << last_k)));
        since_fall = 0;
      end
      if (latch) high_w++;
      if (!clear_n && p_clr)
        chk(since_fall == 1, "R9", "latch fall to clear", 32'(since_fall), 1);
      if (!clear_n) clr_w++;
      if (clear_n && !p_clr) begin
        chk(clr_w == 1, "R9", "clear width", 32'(clr_w), 1);
        clr_w = 0;
      end
      p_sclk = ser_clk;
      p_latch = latch;
      p_clr = clear_n;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    for (int j = 0; j < NCH; j++) model[j] = '0;
    for (int i = 0; i < DEPTH; i++) cur_exp[i] = '0;
    push_frame();  // first frame all zero (R1)
    repeat (4) @(negedge clk);
    chk({ser_clk, ser_data, latch, clear_n, wr_ready} == 5'b00011, "R1",
        "outputs in reset", 32'({ser_clk, ser_data, latch, clear_n, wr_ready}), 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ser_clk, latch, clear_n} == 3'b001, "R1", "outputs after reset",
        32'({ser_clk, latch, clear_n}), 1);
    // Frame 0 playing: new table must not show before frame 1 (R10)
    wait (strobe_cnt == 1);
    for (int j = 0; j < NCH; j++) put(j, 16'h9A5C ^ 16'(j * 16'h0B17), 1'b1);
    push_frame();
    wait (strobe_cnt == DEPTH + 1);
    for (int j = 0; j < NCH; j++) put(j, 16'hFFFF, 1'b1);
    put(5, 16'h0000, 1'b1);
    put(5, 16'h5554, 1'b1);  // last write wins (R2)
    push_frame();
    wait (strobe_cnt == 2 * DEPTH + 1);
    for (int j = 0; j < NCH; j++) put(j, 16'h0003, 1'b1);  // low bits ignored (R3)
    put(7, 16'hFFFF, 1'b0);  // valid low stores nothing (R2)
    push_frame();
    wait (strobe_cnt == 3 * DEPTH + 1);
    put(31, 16'h8004, 1'b1);  // top and bottom planes only (R4)
    push_frame();
    wait (strobe_cnt == 5 * DEPTH + 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule